// File: doc/BRIEF.md
# Display-Enable Activity Link Detector

This block decides whether a video link is alive by watching the display-enable strobe. A live source toggles that strobe on every line. The pixel clock can stop without warning, so the block never uses it. The strobe is brought into the domain of a free-running slow oscillator, and all timing is counted in that domain.

The block drives one flag. The flag is high while the link is judged active and low while it is judged inactive. When the flag is high, the block watches for a long stretch with no strobe transition and lowers the flag once that stretch reaches the timeout. When the flag is low, the block counts strobe transitions inside fixed windows of the same length and raises the flag once enough transitions land in a single window.

The flag is meant to drive the output power-down control of a display receiver. For that reason nothing else in the block gates or disables it.

The controller has two named states:
- `ST_DOWN` is the link-inactive state and the state after reset.
- `ST_UP` is the link-active state.

There are two transitions:
- `GO_UP` goes from `ST_DOWN` to `ST_UP`. It fires when the edge tally reaches its target inside one window.
- `GO_DOWN` goes from `ST_UP` to `ST_DOWN`. It fires when the timer expires with no edge in that cycle.

Top module: `link_activity_monitor`

## Requirements
- R1: While reset is asserted, and after it is released, `link_up` is 0. With no transition on `de_in`, it stays 0 indefinitely.
- R2: `de_in` passes through a two-flop synchronizer. Rising and falling transitions each count as one edge, so four high pulses give eight edges.
- R3: In `ST_DOWN`, the edge that makes `EDGE_TARGET` (default 8) edges within one window of 2^`TIMER_W` oscillator cycles raises `link_up` on the next clock.
- R4: In `ST_DOWN`, when a window ends before the target is reached, the edge tally and the window timer both restart from zero. Edges from separate windows never add up.
- R5: In `ST_UP`, every detected edge restarts the inactivity timer, and `link_up` stays 1.
- R6: In `ST_UP`, `link_up` falls exactly 2^`TIMER_W` oscillator cycles after the last detected edge. A new window then starts from zero.
- R7: Fewer than `EDGE_TARGET` edges inside a window leave `link_up` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock; all logic runs on it |
| osc_rst_n | input | 1 | Asynchronous active-low reset |
| de_in | input | 1 | Display-enable strobe from the pixel-clock domain (asynchronous here) |
| link_up | output | 1 | 1 = link active, 0 = link inactive |

## Verification
The main function is driven with several input patterns, and each separates a different fault:
- **Slow burst of seven edges, then an eighth.** This checks that the target count is exact, neither one early nor one late.
- **Sparse toggling, spaced just inside the timeout, over several timeouts.** This shows whether every edge reloads the timer or only some of them do.
- **A quiet gap after the last edge.** The drop is timed to within a few cycles, so an off-by-one or a wrong counter width shows up.
- **Two half-bursts straddling a window boundary.** These must not combine, which proves the tally is discarded when the window ends.
- **Short pulses.** These confirm that both edge directions are counted.

// File: rtl/lam_pkg.sv
package lam_pkg;

    typedef enum logic {
        ST_DOWN = 1'b0,
        ST_UP   = 1'b1
    } lam_state_t;

endpackage

// File: rtl/lam_de_sync.sv
module lam_de_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic de_async,
    output logic edge_pulse
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= de_async;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], de_async};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    // Either direction of transition is one edge
    assign edge_pulse = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/lam_window_timer.sv
module lam_window_timer #(
    parameter int TIMER_W = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic at_end
);
    localparam logic [TIMER_W-1:0] LAST = {TIMER_W{1'b1}};

    logic [TIMER_W-1:0] cnt_q;

    // Wraps from LAST to zero, so every window is 2^TIMER_W cycles long
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    assign at_end = (cnt_q == LAST);

endmodule

// File: rtl/lam_edge_tally.sv
module lam_edge_tally #(
    parameter int TARGET = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic hit
);
    localparam int CW = $clog2(TARGET + 1);
    localparam logic [CW-1:0] PRE = CW'(TARGET - 1);

    logic [CW-1:0] tally_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tally_q <= '0;
        else if (clear) tally_q <= '0;
        else if (inc)   tally_q <= tally_q + 1'b1;
    end

    assign hit = inc && (tally_q == PRE);

endmodule

// File: rtl/link_activity_monitor.sv
module link_activity_monitor
    import lam_pkg::*;
#(
    parameter int TIMER_W     = 18,
    parameter int EDGE_TARGET = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic osc_rst_n,
    input  logic de_in,
    output logic link_up
);
    lam_state_t state_q, state_d;
    logic edge_seen;
    logic win_end;
    logic tally_hit;
    logic timer_clr;
    logic tally_clr;

    lam_de_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (osc_clk),
        .rst_n      (osc_rst_n),
        .de_async   (de_in),
        .edge_pulse (edge_seen)
    );

    lam_window_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk    (osc_clk),
        .rst_n  (osc_rst_n),
        .clear  (timer_clr),
        .at_end (win_end)
    );

    lam_edge_tally #(.TARGET(EDGE_TARGET)) u_tally (
        .clk   (osc_clk),
        .rst_n (osc_rst_n),
        .clear (tally_clr),
        .inc   (edge_seen && (state_q == ST_DOWN)),
        .hit   (tally_hit)
    );

    // Next state and counter control
    always_comb begin
        state_d   = state_q;
        timer_clr = 1'b0;
        tally_clr = 1'b0;
        unique case (state_q)
            ST_DOWN: begin
                if (tally_hit) begin            // GO_UP
                    state_d   = ST_UP;
                    timer_clr = 1'b1;
                    tally_clr = 1'b1;
                end else if (win_end) begin
                    tally_clr = 1'b1;           // window wraps to zero by itself
                end
            end
            ST_UP: begin
                tally_clr = 1'b1;
                if (edge_seen) begin
                    timer_clr = 1'b1;
                end else if (win_end) begin     // GO_DOWN
                    state_d = ST_DOWN;
                end
            end
            default: state_d = ST_DOWN;
        endcase
    end

    // State register
    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) state_q <= ST_DOWN;
        else            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        link_up = (state_q == ST_UP);
    end

endmodule

// File: rtl/lam_checker.sv
module lam_checker #(
    parameter int TIMER_W = 18
) (
    input logic clk,
    input logic rst_n,
    input logic edge_pulse,
    input logic link_up
);
    localparam logic [TIMER_W:0] LIMIT = (TIMER_W + 1)'(1) << TIMER_W;

    logic [TIMER_W:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    quiet_q <= '0;
        else if (edge_pulse || !link_up) quiet_q <= '0;
        else                           quiet_q <= quiet_q + 1'b1;
    end

    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |-> !link_up); // R1

    AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(edge_pulse)); // R3

    AST_UP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && edge_pulse) |=> link_up); // R5

    AST_FALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_up) |-> !$past(edge_pulse)); // R6

    AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> (quiet_q <= LIMIT)); // R6

endmodule

bind link_activity_monitor lam_checker #(.TIMER_W(TIMER_W)) u_lam_chk (
    .clk        (osc_clk),
    .rst_n      (osc_rst_n),
    .edge_pulse (edge_seen),
    .link_up    (link_up)
);

// File: tb/tb_link_activity_monitor.sv
module tb_link_activity_monitor;
    localparam int TW = 6;               // window = 64 cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic de = 1'b0;
    logic link_up;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;                // 125 MHz

    link_activity_monitor #(.TIMER_W(TW), .EDGE_TARGET(8), .SYNC_STAGES(2)) dut (
        .osc_clk   (clk),
        .osc_rst_n (rst_n),
        .de_in     (de),
        .link_up   (link_up)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic toggle(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            de = ~de;
            cyc(gap - 1);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        de = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;              // R1
        do_reset();
        chk(link_up == 1'b0, "R1 after reset", link_up, 0);
        cyc(150);
        chk(link_up == 1'b0, "R1 idle stays low", link_up, 0);
    endtask

    task automatic t_raise;              // R7 then R3
        do_reset();
        toggle(7, 3);
        cyc(6);
        chk(link_up == 1'b0, "R7 seven edges", link_up, 0);
        toggle(1, 1);
        cyc(5);
        chk(link_up == 1'b1, "R3 eighth edge", link_up, 1);
    endtask

    task automatic t_hold;               // R5
        for (int k = 0; k < 6; k++) begin
            toggle(1, 40);
            chk(link_up == 1'b1, "R5 sparse edges", link_up, 1);
        end
    endtask

    task automatic t_drop;               // R6
        int n;
        n = 0;
        toggle(1, 1);
        cyc(60);
        n = 61;
        chk(link_up == 1'b1, "R6 before timeout", link_up, 1);
        while (link_up && n < 90) begin
            cyc(1);
            n++;
        end
        chk(n >= 65 && n <= 69, "R6 drop time", n, 67);
        chk(link_up == 1'b0, "R6 low after timeout", link_up, 0);
    endtask

    task automatic t_split;              // R4, called right after the drop
        toggle(5, 2);
        cyc(60);
        toggle(5, 2);
        cyc(4);
        chk(link_up == 1'b0, "R4 split windows", link_up, 0);
        toggle(3, 2);
        cyc(4);
        chk(link_up == 1'b1, "R4 eight in new window", link_up, 1);
    endtask

    task automatic t_pulses;             // R2
        cyc(80);
        chk(link_up == 1'b0, "R2 precondition low", link_up, 0);
        for (int i = 0; i < 4; i++) begin
            toggle(1, 2);
            toggle(1, 2);
        end
        cyc(5);
        chk(link_up == 1'b1, "R2 four pulses", link_up, 1);
    endtask

    initial begin
        t_reset();
        t_raise();
        t_hold();
        t_drop();
        t_split();
        t_pulses();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule